// File: doc/BRIEF.md
# GCI Link Activation Sequencer

This block manages the activation and deactivation handshake between a controller and a layer-1 line device over a GCI-style frame interface. It samples the interface clock with a free-running system clock. A programmable idle counter tells whether the interface clock is present. A stopped clock means the link is deactivated. While deactivated, the receive line rests high, so the received command/indication code reads as all ones.

When the line device restarts the clock and places an indication in the channel 0 C/I field, the block accepts that code. The code must arrive unchanged in two frames in a row. On acceptance the block marks the link active and sets an interrupt-pending flag, which an enable bit can mask. Software clears the flag by pulsing a clear input.

To request activation, software sets a force-zero bit. While the bit is held, the transmit line stays at zero and the timing command code 0 is presented as the outgoing C/I code. Once the line device has resumed the clock and reported activation, software drops the bit. Normal output then resumes, carrying the software command code in the C/I slots.

Top module: `gci_link_activator`

## Requirements
- R1: After reset, tx_data is 1, irq and irq_pending are 0, clk_alive and link_active are 0, and rx_ci_code is 4'hF.
- R2: If no rising edge of gci_clk is seen for idle_limit system cycles, clk_alive drops, link_active clears and rx_ci_code returns to 4'hF. A gap shorter than idle_limit keeps clk_alive high.
- R3: A rising edge of gci_clk sets clk_alive.
- R4: A rising gci_clk edge with gci_fsync high marks bit slot 0 of a 32-slot frame. The channel 0 C/I code sits in slots 24 to 27, most significant bit first in slot 24.
- R5: rx_ci_code takes a received C/I code only when that code arrives identical in two consecutive frames and differs from the current rx_ci_code. Acceptance also sets link_active.
- R6: irq_pending is set when a code is accepted. It stays set until a cycle with irq_clear high.
- R7: irq is high exactly when irq_pending and irq_enable are both high.
- R8: While force_zero is high, tx_data is 0 and tx_ci_code is 4'h0 (timing command).
- R9: With force_zero low and the clock alive, tx_data carries tx_ci_cmd in slots 24 to 27, most significant bit first, and 1 in every other slot. With the clock absent, tx_data is 1.
- R10: With force_zero low, tx_ci_code equals tx_ci_cmd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gci_clk | input | 1 | Interface bit clock from the line device |
| gci_fsync | input | 1 | Frame sync, high during slot 0 |
| gci_rxd | input | 1 | Serial receive data |
| idle_limit | input | 16 | System cycles without an interface edge before the clock counts as stopped |
| tx_ci_cmd | input | 4 | Command code for the C/I field in normal operation |
| force_zero | input | 1 | Software activation request: hold output at zero |
| irq_enable | input | 1 | Interrupt mask, 1 lets irq through |
| irq_clear | input | 1 | Clears irq_pending when high |
| tx_data | output | 1 | Serial transmit data |
| tx_ci_code | output | 4 | C/I code currently being sent |
| rx_ci_code | output | 4 | Last accepted received indication |
| irq | output | 1 | Masked interrupt |
| irq_pending | output | 1 | Unmasked interrupt flag |
| clk_alive | output | 1 | Interface clock present |
| link_active | output | 1 | Link activated by an accepted indication |

## Verification
Several properties are checked on every cycle: force-zero drives both outputs to zero, the pending flag holds until it is cleared, any change of the accepted code while the clock runs comes with the pending flag, and an active link always has a live clock. The two-frame acceptance filter can only be shown by the bench's frame sequences. The same holds for rejection of alternating codes and of repeats of the current code, the serial slot placement of the transmitted command, and the timeout boundary just below and above idle_limit.

// File: rtl/gci_link_activator.sv
module gci_link_activator #(
  parameter int FRAME_BITS = 32,
  parameter int CI_POS     = 24,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gci_clk,
  input  logic             gci_fsync,
  input  logic             gci_rxd,
  input  logic [CNT_W-1:0] idle_limit,
  input  logic [3:0]       tx_ci_cmd,
  input  logic             force_zero,
  input  logic             irq_enable,
  input  logic             irq_clear,
  output logic             tx_data,
  output logic [3:0]       tx_ci_code,
  output logic [3:0]       rx_ci_code,
  output logic             irq,
  output logic             irq_pending,
  output logic             clk_alive,
  output logic             link_active
);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] CI_FIRST = BIT_W'(CI_POS);
  localparam logic [BIT_W-1:0] CI_LAST  = BIT_W'(CI_POS + 3);
  localparam logic [BIT_W-1:0] LAST_SLOT = BIT_W'(FRAME_BITS - 1);

  logic [2:0]       ck_s;
  logic [1:0]       fs_s, rx_s;
  logic [CNT_W-1:0] idle_cnt;
  logic [BIT_W-1:0] slot;
  logic             framed;
  logic [2:0]       ci_sh;
  logic [3:0]       cand;
  logic             cand_valid;

  wire rise    = ck_s[1] & ~ck_s[2];
  wire rx_ok   = fs_s[1] | framed;
  wire [BIT_W-1:0] idx_now = fs_s[1] ? '0 : ((slot == LAST_SLOT) ? '0 : slot + 1'b1);
  wire in_rx_ci = rx_ok && idx_now >= CI_FIRST && idx_now <= CI_LAST;
  wire [3:0] code_full = {ci_sh, rx_s[1]};
  wire code_done = rise && rx_ok && idx_now == CI_LAST;
  wire accept = code_done && cand_valid && code_full == cand && code_full != rx_ci_code;
  wire timeout = !rise && clk_alive && idle_cnt >= idle_limit;

  wire in_tx_ci = framed && slot >= CI_FIRST && slot <= CI_LAST;
  wire [1:0] ci_off = 2'(slot - CI_FIRST);

  assign tx_data    = force_zero ? 1'b0 : ((clk_alive && in_tx_ci) ? tx_ci_cmd[2'd3 - ci_off] : 1'b1);
  assign tx_ci_code = force_zero ? 4'h0 : tx_ci_cmd;
  assign irq        = irq_pending & irq_enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_s <= '0;
      fs_s <= '0;
      rx_s <= '1;
    end else begin
      ck_s <= {ck_s[1:0], gci_clk};
      fs_s <= {fs_s[0], gci_fsync};
      rx_s <= {rx_s[0], gci_rxd};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      clk_alive <= 1'b0;
    end else if (rise) begin
      idle_cnt  <= '0;
      clk_alive <= 1'b1;
    end else if (timeout) begin
      clk_alive <= 1'b0;
    end else if (clk_alive) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || timeout) begin
      slot       <= '0;
      framed     <= 1'b0;
      ci_sh      <= '1;
      cand       <= 4'hF;
      cand_valid <= 1'b0;
    end else if (rise) begin
      slot <= idx_now;
      if (fs_s[1]) framed <= 1'b1;
      if (in_rx_ci) ci_sh <= {ci_sh[1:0], rx_s[1]};
      if (code_done) begin
        cand       <= code_full;
        cand_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || timeout) begin
      rx_ci_code  <= 4'hF;
      link_active <= 1'b0;
    end else if (accept) begin
      rx_ci_code  <= code_full;
      link_active <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         irq_pending <= 1'b0;
    else if (accept)    irq_pending <= 1'b1;
    else if (irq_clear) irq_pending <= 1'b0;
  end

  AST_FORCE_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    force_zero |-> (!tx_data && tx_ci_code == 4'h0)); // R8

  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_clear) |=> irq_pending); // R6

  AST_EDGE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> clk_alive); // R3

  AST_LINK_NEEDS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    link_active |-> clk_alive); // R2

  AST_CODE_CHANGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ci_code != $past(rx_ci_code) && clk_alive) |-> irq_pending); // R5

  AST_STOP_RESTORES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clk_alive) && !clk_alive) |-> (!link_active && rx_ci_code == 4'hF)); // R2
endmodule

// File: tb/gci_link_activator_test.sv
module gci_link_activator_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        gci_clk = 0, gci_fsync = 0, gci_rxd = 1;
  logic [15:0] idle_limit = 16'd40;
  logic [3:0]  tx_ci_cmd = 4'hA;
  logic        force_zero = 0, irq_enable = 0, irq_clear = 0;
  logic        tx_data, irq, irq_pending, clk_alive, link_active;
  logic [3:0]  tx_ci_code, rx_ci_code;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [31:0] tx_seen;
  logic        txc_zero;
  logic [3:0]  exp_q[$];
  logic [3:0]  seen_ci = 4'hF;

  always #4 clk = ~clk;

  gci_link_activator uut (
    .clk(clk), .rst_n(rst_n), .gci_clk(gci_clk), .gci_fsync(gci_fsync), .gci_rxd(gci_rxd),
    .idle_limit(idle_limit), .tx_ci_cmd(tx_ci_cmd), .force_zero(force_zero),
    .irq_enable(irq_enable), .irq_clear(irq_clear), .tx_data(tx_data), .tx_ci_code(tx_ci_code),
    .rx_ci_code(rx_ci_code), .irq(irq), .irq_pending(irq_pending), .clk_alive(clk_alive),
    .link_active(link_active)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_ci(input logic [3:0] v);
    exp_q.push_back(v);
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_ci_code !== seen_ci) begin
      seen_ci = rx_ci_code;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5: actual=%h expected=no change", rx_ci_code);
      end else begin
        check("R5 accepted code order", {28'd0, rx_ci_code}, {28'd0, exp_q.pop_front()});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic send_frame(input logic [3:0] ci);
    txc_zero = 1;
    for (int b = 0; b < 32; b++) begin
      gci_fsync = (b == 0);
      gci_rxd   = (b >= 24 && b <= 27) ? ci[27 - b] : 1'b1;
      gci_clk   = 0;
      repeat (4) @(negedge clk);
      gci_clk = 1;
      repeat (4) @(negedge clk);
      tx_seen[b] = tx_data;
      if (tx_ci_code != 4'h0) txc_zero = 0;
    end
    gci_fsync = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 tx_data", tx_data, 1);
    check("R1 irq", {irq, irq_pending}, 0);
    check("R1 alive/link", {clk_alive, link_active}, 0);
    check("R1 rx_ci_code", rx_ci_code, 4'hF);
    check("R10 tx_ci_code", tx_ci_code, 4'hA);
    check("R9 dead clock tx", tx_data, 1);

    irq_enable = 1;
    send_frame(4'h8);
    check("R3 clk_alive", clk_alive, 1);
    check("R5 single frame not accepted", {link_active, irq_pending, rx_ci_code}, {2'b00, 4'hF});
    check("R4 R9 tx slots", tx_seen, 32'hF5FF_FFFF);

    expect_ci(4'h8);
    send_frame(4'h8);
    check("R5 link_active", link_active, 1);
    check("R6 pending set", irq_pending, 1);
    check("R7 irq enabled", irq, 1);
    irq_enable = 0;
    @(negedge clk);
    check("R7 irq masked", {irq, irq_pending}, 2'b01);
    irq_clear = 1; @(negedge clk); irq_clear = 0; @(negedge clk);
    check("R6 pending cleared", irq_pending, 0);

    send_frame(4'hC);
    send_frame(4'h3);
    check("R5 alternating rejected", rx_ci_code, 4'h8);
    expect_ci(4'h3);
    send_frame(4'h3);
    check("R5 new code", rx_ci_code, 4'h3);
    check("R6 pending on new code", irq_pending, 1);
    irq_clear = 1; @(negedge clk); irq_clear = 0;
    send_frame(4'h3);
    send_frame(4'h3);
    check("R5 repeat of current ignored", irq_pending, 0);

    force_zero = 1;
    send_frame(4'h3);
    check("R8 tx held low", tx_seen, 32'h0);
    check("R8 timing command", txc_zero, 1);
    force_zero = 0;
    tx_ci_cmd = 4'h6;
    @(negedge clk);
    check("R10 cmd after release", tx_ci_code, 4'h6);
    send_frame(4'h3);
    check("R9 tx after release", tx_seen, 32'hF6FF_FFFF);

    repeat (30) @(negedge clk);
    check("R2 short gap keeps clock", {clk_alive, link_active}, 2'b11);
    expect_ci(4'hF);
    repeat (40) @(negedge clk);
    check("R2 stopped clock", {clk_alive, link_active}, 2'b00);
    check("R2 code idle", rx_ci_code, 4'hF);
    check("R9 idle line high", tx_data, 1);
    check("R5 queue drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule